// File: doc/BRIEF.md
# Console Run/Halt Sequencer

This block is the operator console's control sequencer for a processor core. It watches a level HALT switch, a level step-granularity switch, and two momentary push switches, START and CONT. From them it produces the core's cycle enable, a bus reset pulse of fixed length, and a one-clock pulse that clears the memory management unit. It also reports whether the core is running.

START and CONT both set the core's clocks running. They differ in one way: START always issues a reset first and CONT never does. When HALT is up, START resets and then runs the core. When HALT is down, START only resets and the core stays stopped. CONT with HALT up resumes from where the core stopped. CONT with HALT down advances the core by one instruction or by one machine cycle, as the step switch selects.

While the core runs, lowering HALT does not stop it at once. The core stops at the next instruction boundary, or at the next cycle when cycle granularity is selected. The core reports both points through strobe inputs.

Top module: `panel_runctl`

## Requirements
- R1: After a synchronous reset, `cyc_en`, `running`, `bus_rst` and `mmu_clr` are all low.
- R2: START and CONT act on their rising edge only. A switch held for any number of clocks causes exactly one action, and it must be released before it can act again.
- R3: In every state, and whatever the HALT level, a START press drives `bus_rst` high for exactly RST_CYCLES consecutive clocks. The pulse begins in the clock after the press is sampled. `cyc_en` is low throughout the pulse.
- R4: A START press drives `mmu_clr` high for exactly one clock, in the first clock of the bus reset pulse.
- R5: A START press taken with HALT low (`sw_halt`=0) raises `cyc_en` in the clock right after the last `bus_rst` clock.
- R6: A START press taken with HALT high (`sw_halt`=1) leaves `cyc_en` low after the bus reset ends.
- R7: From the halted state, CONT with HALT low raises `cyc_en` in the next clock and produces no `bus_rst` or `mmu_clr`.
- R8: From the halted state, CONT with HALT high and `sw_step_cycle`=0 raises `cyc_en` in the next clock. `cyc_en` stays high until a clock in which `core_ibound`=1 is sampled, and drops in the following clock. `core_cyc` has no effect on this.
- R9: From the halted state, CONT with HALT high and `sw_step_cycle`=1 behaves the same way, except that the step ends on a sampled `core_cyc`=1. `core_ibound` is ignored.
- R10: While running with HALT high and `sw_step_cycle`=0, the core keeps running through `core_cyc` pulses. `cyc_en` drops in the clock after a sampled `core_ibound`=1.
- R11: While running with HALT high and `sw_step_cycle`=1, `cyc_en` drops in the clock after a sampled `core_cyc`=1.
- R12: `running` equals `cyc_en` in every clock. A CONT press while `cyc_en` is high, or during a bus reset pulse, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_halt | input | 1 | HALT switch level, 1 = halt requested |
| sw_step_cycle | input | 1 | Stop granularity: 0 = instruction, 1 = machine cycle |
| sw_start | input | 1 | START push switch, debounced level |
| sw_cont | input | 1 | CONT push switch, debounced level |
| core_ibound | input | 1 | Core strobe: an instruction boundary (next fetch) is reached this clock |
| core_cyc | input | 1 | Core strobe: a machine cycle completes this clock |
| cyc_en | output | 1 | Clock/cycle enable to the core |
| bus_rst | output | 1 | Bus reset pulse |
| mmu_clr | output | 1 | One-clock memory management clear pulse |
| running | output | 1 | Run status, high while the core is enabled |

## Verification
The assertions check four things on every clock: the stop rules for each granularity, the bar on `cyc_en` and `bus_rst` being high together, the placement of `mmu_clr` inside the reset pulse, and that every rise of `cyc_en` outside a reset release is caused by CONT. Other behaviour spans a whole sequence of presses, so only the bench scenarios, compared clock by clock against a behavioural model, can show it. That covers the exact pulse length, the START outcome chosen by HALT, CONT being ignored while running or resetting, and held switches acting once.

// File: rtl/panel_pkg.sv
package panel_pkg;

    typedef enum logic [1:0] {
        PS_HALTED = 2'd0,
        PS_RESET  = 2'd1,
        PS_RUN    = 2'd2,
        PS_STEP   = 2'd3
    } pstate_e;

    typedef struct packed {
        logic start;
        logic cont;
    } press_t;

    localparam int unsigned NUM_KEYS = 2;

    // select the strobe that marks a legal stopping point
    function automatic logic stop_point(input logic cycle_gran,
                                        input logic ibound,
                                        input logic cyc);
        return cycle_gran ? cyc : ibound;
    endfunction

    function automatic logic enables_core(input pstate_e s);
        return (s == PS_RUN) || (s == PS_STEP);
    endfunction

endpackage

// File: rtl/panel_edge.sv
module panel_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_key
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/panel_rst_timer.sv
module panel_rst_timer #(
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy,
    output logic last
);
    localparam int unsigned CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load)           cnt_q <= CW'(RST_CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/panel_seq.sv
module panel_seq
    import panel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  press_t press,
    input  logic   halt,
    input  logic   cycle_gran,
    input  logic   ibound,
    input  logic   cyc,
    input  logic   rst_last,
    output logic   load_rst,
    output logic   core_en,
    output logic   mmu_pulse
);
    pstate_e state_q, state_d;
    logic    go_q, go_d;
    logic    mmu_q;
    logic    at_stop;

    assign at_stop  = stop_point(cycle_gran, ibound, cyc);
    assign load_rst = press.start;

    always_comb begin
        state_d = state_q;
        go_d    = go_q;
        if (press.start) begin
            state_d = PS_RESET;
            go_d    = ~halt;
        end else begin
            unique case (state_q)
                PS_HALTED: if (press.cont) state_d = halt ? PS_STEP : PS_RUN;
                PS_RESET:  if (rst_last)   state_d = go_q ? PS_RUN : PS_HALTED;
                PS_RUN:    if (halt && at_stop) state_d = PS_HALTED;
                PS_STEP:   if (at_stop)    state_d = PS_HALTED;
                default:   state_d = PS_HALTED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_HALTED;
            go_q    <= 1'b0;
            mmu_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            go_q    <= go_d;
            mmu_q   <= press.start;
        end
    end

    assign core_en   = enables_core(state_q);
    assign mmu_pulse = mmu_q;
endmodule

// File: rtl/panel_runctl.sv
module panel_runctl
    import panel_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_halt,
    input  logic sw_step_cycle,
    input  logic sw_start,
    input  logic sw_cont,
    input  logic core_ibound,
    input  logic core_cyc,
    output logic cyc_en,
    output logic bus_rst,
    output logic mmu_clr,
    output logic running
);
    logic [NUM_KEYS-1:0] key_rise;
    press_t              press;
    logic                load_rst, rst_busy, rst_last, core_en;

    panel_edge #(.N(NUM_KEYS)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl ({sw_start, sw_cont}),
        .rise(key_rise)
    );

    assign press = press_t'(key_rise);

    panel_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
        .clk (clk),
        .rst (rst),
        .load(load_rst),
        .busy(rst_busy),
        .last(rst_last)
    );

    panel_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .press     (press),
        .halt      (sw_halt),
        .cycle_gran(sw_step_cycle),
        .ibound    (core_ibound),
        .cyc       (core_cyc),
        .rst_last  (rst_last),
        .load_rst  (load_rst),
        .core_en   (core_en),
        .mmu_pulse (mmu_clr)
    );

    assign cyc_en  = core_en;
    assign bus_rst = rst_busy;
    assign running = core_en;
endmodule

// File: rtl/panel_runctl_chk.sv
module panel_runctl_chk (
    input logic clk,
    input logic rst,
    input logic sw_halt,
    input logic sw_step_cycle,
    input logic sw_start,
    input logic sw_cont,
    input logic core_ibound,
    input logic core_cyc,
    input logic cyc_en,
    input logic bus_rst,
    input logic mmu_clr,
    input logic running
);
    // R3
    rst_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rst && cyc_en));

    // R4
    mmu_in_rst_chk: assert property (@(posedge clk) disable iff (rst)
        mmu_clr |-> bus_rst);

    // R4
    mmu_single_chk: assert property (@(posedge clk) disable iff (rst)
        mmu_clr |=> !mmu_clr);

    // R7
    cont_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cyc_en) && !$past(bus_rst)) |-> $past(sw_cont));

    // R8
    istop_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && sw_halt && !sw_step_cycle && core_ibound && !sw_start) |=> !cyc_en);

    // R10
    ihold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && sw_halt && !sw_step_cycle && !core_ibound && !sw_start) |=> cyc_en);

    // R11
    cstop_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && sw_halt && sw_step_cycle && core_cyc && !sw_start) |=> !cyc_en);

    // R9
    chold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && sw_halt && sw_step_cycle && !core_cyc && !sw_start) |=> cyc_en);

    // R12
    status_chk: assert property (@(posedge clk) disable iff (rst)
        running == cyc_en);
endmodule

bind panel_runctl panel_runctl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sw_halt      (sw_halt),
    .sw_step_cycle(sw_step_cycle),
    .sw_start     (sw_start),
    .sw_cont      (sw_cont),
    .core_ibound  (core_ibound),
    .core_cyc     (core_cyc),
    .cyc_en       (cyc_en),
    .bus_rst      (bus_rst),
    .mmu_clr      (mmu_clr),
    .running      (running)
);

// File: tb/panel_runctl_tb.sv
module panel_runctl_tb;
    localparam int RST = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_halt = 0, sw_step_cycle = 0, sw_start = 0, sw_cont = 0;
    logic core_ibound = 0, core_cyc = 0;
    logic cyc_en, bus_rst, mmu_clr, running;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    panel_runctl #(.RST_CYCLES(RST)) u_dut (
        .clk(clk), .rst(rst), .sw_halt(sw_halt), .sw_step_cycle(sw_step_cycle),
        .sw_start(sw_start), .sw_cont(sw_cont), .core_ibound(core_ibound),
        .core_cyc(core_cyc), .cyc_en(cyc_en), .bus_rst(bus_rst),
        .mmu_clr(mmu_clr), .running(running)
    );

    always #5 clk = ~clk;

    // behavioural reference: 0 halted, 1 resetting, 2 running, 3 stepping
    int m_st = 0, m_cnt = 0;
    bit m_go = 0, m_mmu = 0, m_ps = 0, m_pc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit sp, cp, stop;
        cycles++;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_go = 0; m_mmu = 0; m_ps = 0; m_pc = 0;
        end else begin
            sp = sw_start && !m_ps;
            cp = sw_cont && !m_pc;
            m_ps = sw_start;
            m_pc = sw_cont;
            stop = sw_step_cycle ? core_cyc : core_ibound;
            m_mmu = sp;
            if (sp) begin
                m_st = 1; m_cnt = RST; m_go = !sw_halt;
            end else if (m_st == 1) begin
                m_cnt--;
                if (m_cnt == 0) m_st = m_go ? 2 : 0;
            end else if (m_st == 2) begin
                if (sw_halt && stop) m_st = 0;
            end else if (m_st == 3) begin
                if (stop) m_st = 0;
            end else if (cp) begin
                m_st = sw_halt ? 3 : 2;
            end
        end
        #2;
        if (!rst) begin
            chk(cyc_en === (m_st >= 2), "model cyc_en R5 R7 R8 R9 R10 R11", cyc_en, m_st >= 2);
            chk(bus_rst === (m_st == 1), "model bus_rst R3", bus_rst, m_st == 1);
            chk(mmu_clr === m_mmu, "model mmu_clr R4", mmu_clr, m_mmu);
            chk(running === cyc_en, "model running R12", running, cyc_en);
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        // R1 reset state
        chk({cyc_en, bus_rst, mmu_clr, running} == 4'b0, "R1 reset outputs",
            {cyc_en, bus_rst, mmu_clr, running}, 0);
        rst = 0;
        tick(2);

        // R3 R4 R5: START with halt low, held long (R2)
        sw_start = 1;
        tick();
        chk(bus_rst == 1, "R3 pulse begins", bus_rst, 1);
        chk(mmu_clr == 1, "R4 mmu first cycle", mmu_clr, 1);
        for (int k = 2; k <= RST; k++) begin
            tick();
            chk(bus_rst == 1 && cyc_en == 0, "R3 pulse body", bus_rst, 1);
            chk(mmu_clr == 0, "R4 mmu single", mmu_clr, 0);
        end
        tick();
        chk(bus_rst == 0, "R3 pulse length", bus_rst, 0);
        chk(cyc_en == 1, "R5 run after reset", cyc_en, 1);
        tick(8);
        chk(bus_rst == 0 && cyc_en == 1, "R2 held START acts once", bus_rst, 0);
        sw_start = 0;

        // R10: running, halt, instruction granularity
        sw_halt = 1; sw_step_cycle = 0;
        core_cyc = 1; tick(3); core_cyc = 0;
        chk(cyc_en == 1, "R10 cycle strobes ignored", cyc_en, 1);
        core_ibound = 1; tick(); core_ibound = 0;
        chk(cyc_en == 0, "R10 stop at boundary", cyc_en, 0);

        // R8: single instruction step, CONT held (R2)
        sw_cont = 1; tick();
        chk(cyc_en == 1, "R8 step begins", cyc_en, 1);
        core_cyc = 1; tick(2); core_cyc = 0;
        chk(cyc_en == 1, "R8 waits for boundary", cyc_en, 1);
        core_ibound = 1; tick(); core_ibound = 0;
        chk(cyc_en == 0, "R8 step ends", cyc_en, 0);
        tick(4);
        chk(cyc_en == 0, "R2 held CONT steps once", cyc_en, 0);
        sw_cont = 0; tick();

        // R9: single cycle step
        sw_step_cycle = 1;
        sw_cont = 1; tick(); sw_cont = 0;
        chk(cyc_en == 1, "R9 step begins", cyc_en, 1);
        core_ibound = 1; tick(); core_ibound = 0;
        chk(cyc_en == 1, "R9 boundary ignored", cyc_en, 1);
        core_cyc = 1; tick(); core_cyc = 0;
        chk(cyc_en == 0, "R9 step ends", cyc_en, 0);

        // R7: resume, no reset; R12: CONT while running ignored
        sw_halt = 0;
        sw_cont = 1; tick(); sw_cont = 0;
        chk(cyc_en == 1 && bus_rst == 0 && mmu_clr == 0, "R7 resume without reset",
            {cyc_en, bus_rst, mmu_clr}, 3'b100);
        tick();
        sw_cont = 1; tick(); sw_cont = 0; tick();
        chk(cyc_en == 1 && bus_rst == 0 && running == 1, "R12 CONT while running", cyc_en, 1);

        // R11: halt in cycle granularity while running
        sw_halt = 1; sw_step_cycle = 1;
        tick(2);
        chk(cyc_en == 1, "R11 waits for cycle", cyc_en, 1);
        core_cyc = 1; tick(); core_cyc = 0;
        chk(cyc_en == 0 && running == 0, "R11 stop at cycle", cyc_en, 0);

        // R6: START with halt high, CONT during reset ignored (R12)
        sw_start = 1; tick(); sw_start = 0;
        chk(bus_rst == 1 && mmu_clr == 1, "R6 reset issued", bus_rst, 1);
        sw_cont = 1; tick(); sw_cont = 0;
        tick(RST + 2);
        chk(cyc_en == 0 && bus_rst == 0, "R6 stays halted", cyc_en, 0);
        chk(running == 0, "R12 CONT during reset ignored", running, 0);

        // R3: START while running resets, then resumes
        sw_halt = 0;
        sw_cont = 1; tick(); sw_cont = 0;
        tick(2);
        sw_start = 1; tick(); sw_start = 0;
        chk(bus_rst == 1 && cyc_en == 0, "R3 START while running", bus_rst, 1);
        tick(RST);
        chk(cyc_en == 1 && bus_rst == 0, "R5 resume after running reset", cyc_en, 1);

        tick(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule